// File: doc/BRIEF.md
# Remote Terminal Command Legality and Descriptor Sequencer

This block sits behind the word decoder of a remote-terminal engine. For each decoded command it takes the broadcast flag, the transmit/receive direction, the subaddress-or-mode-code flag and the 5-bit subaddress or mode-code number. It decides from sixteen 16-bit illegalization bitmaps whether the terminal may respond. A legal command has a 4-word descriptor in local memory. The block computes the descriptor's address, gains the local memory bus by a DMA request/grant handshake, and reads the descriptor in one burst. It then presents the current data-buffer address to the data-word engine.

When the data-word engine reports the end of the message, the block computes the next buffer position. It either rewinds to the top of the buffer or advances by the number of words moved. It then regains the bus and writes back the message-information buffer and the descriptor. If interrupt-when-accessed is set and interrupts are enabled, it also appends an entry to a circular interrupt log and raises a one-clock interrupt. An illegal command touches no memory and produces a one-clock flag for the status-word logic.

The controller has six states:
- ST_IDLE accepts a command. A legal one moves to ST_FREQ, and an illegal one stays in ST_IDLE with the flag.
- ST_FREQ requests the bus and moves to ST_FETCH on grant.
- ST_FETCH performs four reads, then moves to ST_ACTIVE.
- ST_ACTIVE presents the buffer address and moves to ST_WREQ on message end.
- ST_WREQ requests the bus again and moves to ST_WRITE on grant.
- ST_WRITE performs four or six writes, then returns to ST_IDLE.

Top module: `rt_desc_ctrl`

## Requirements
- R1: The category index is cat = 4*cmd_mode + 2*cmd_bcast + cmd_tx, giving receive 0, transmit 1, broadcast receive 2, broadcast transmit 3, and mode codes 4 to 7 in the same order. The bitmap register is number 2*cat + cmd_sa[4]. It occupies ill_regs[16*k+15:16*k], and bit cmd_sa[3:0] of it set to 1 makes the command illegal.
- R2: A broadcast transmit mode code (cmd_bcast=1, cmd_tx=1, cmd_mode=1) with number 16 to 31 is illegal whatever ill_regs holds.
- R3: A command accepted in ST_IDLE that is illegal raises cmd_illegal for exactly the following clock cycle. No dma_req and no memory read or write follow from it.
- R4: The descriptor address is desc_base + 256*cmd_mode + 128*cmd_tx + 4*cmd_sa. It is fetched as four reads at that address plus 0, 1, 2, 3, which are the control word, top address, current address and message-information-buffer address.
- R5: mem_rd and mem_wr are asserted only while dma_req is high and dma_gnt_n is low. The first fetch read comes two cycles after the bus request begins if the grant is immediate, and one cycle later for each cycle the grant is withheld.
- R6: After the fetch, buf_valid is high and buf_addr equals the fetched current address until msg_done.
- R7: The write-back order is: msg_info to the buffer address, msg_tag to the buffer address+1, the new current address to the descriptor+2, then the unchanged control word to the descriptor+0.
- R8: If control bit 6 is set, the new current address is the top address. Otherwise it is the old current address plus msg_words.
- R9: If control bit 8 is set and irq_en is high, two more words follow: msg_info to log_base+2*i and the descriptor address to log_base+2*i+1. msg_irq pulses for one clock after the last write, and i advances modulo LOG_DEPTH (default 4). Otherwise exactly four words are written and no pulse occurs.
- R10: cmd_valid outside ST_IDLE is ignored: no illegal flag, and no change to the message in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded command present for one cycle |
| cmd_bcast | input | 1 | Command is broadcast |
| cmd_tx | input | 1 | Command is transmit (1) or receive (0) |
| cmd_mode | input | 1 | Field is a mode code (1) or subaddress (0) |
| cmd_sa | input | 5 | Subaddress or mode-code number |
| desc_base | input | 16 | Base address of descriptor space |
| log_base | input | 16 | Base address of interrupt log ring |
| ill_regs | input | 256 | Sixteen 16-bit illegalization bitmaps |
| irq_en | input | 1 | Global interrupt enable |
| msg_done | input | 1 | Message complete, one cycle |
| msg_words | input | 6 | Data words moved in the message |
| msg_info | input | 16 | Message information word |
| msg_tag | input | 16 | Time tag of the message |
| dma_req | output | 1 | Local bus request |
| dma_gnt_n | input | 1 | Local bus grant, active low |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe, data returned same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| cmd_illegal | output | 1 | One-cycle illegal-command flag |
| buf_valid | output | 1 | Buffer address valid |
| buf_addr | output | 16 | Current data buffer address |
| msg_irq | output | 1 | One-cycle message interrupt |

## Verification
The bench aims at bitmaps in the upper half of a category, so a design that ignored sa[4] would block or pass the wrong command. It also checks the forced broadcast-transmit mode-code rule next to the legal mode code 15 just below it. Descriptors with and without the rewind bit catch a buffer pointer that always advances or never does. A descriptor with interrupt-when-accessed, run with irq_en both high and low, shows a wrong burst length as a missing or extra write. Five log entries catch a log ring that fails to wrap. A delayed grant catches a design that touches memory before ownership. A command issued mid-message catches a controller that accepts work while busy.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREQ,
        ST_FETCH,
        ST_ACTIVE,
        ST_WREQ,
        ST_WRITE
    } rtd_state_t;

    localparam int CTL_WRAP_BIT = 6;
    localparam int CTL_IWA_BIT  = 8;
    localparam logic [2:0] LAST_SHORT = 3'd3;
    localparam logic [2:0] LAST_LONG  = 3'd5;
endpackage

// File: rtl/rtd_legality.sv
module rtd_legality #(
    parameter int SA_W = 5
) (
    input  logic                                 bcast,
    input  logic                                 tx,
    input  logic                                 mode,
    input  logic [SA_W-1:0]                      sa,
    input  logic [16*(1<<(SA_W-1))-1:0]          regs,
    output logic                                 legal
);
    localparam int HALF = 1 << (SA_W - 1);

    logic [3:0]      idx;
    logic [HALF-1:0] map_word;
    logic            forced;

    assign idx      = {mode, bcast, tx, sa[SA_W-1]};
    assign map_word = regs[32'(idx) * HALF +: HALF];
    assign forced   = mode & bcast & tx & sa[SA_W-1];
    assign legal    = ~map_word[sa[SA_W-2:0]] & ~forced;
endmodule

// File: rtl/rtd_addr_gen.sv
module rtd_addr_gen #(
    parameter int AW   = 16,
    parameter int SA_W = 5
) (
    input  logic [AW-1:0]   base,
    input  logic            tx,
    input  logic            mode,
    input  logic [SA_W-1:0] sa,
    output logic [AW-1:0]   desc
);
    localparam int OFF_W = SA_W + 4;

    logic [OFF_W-1:0] offset;

    assign offset = {mode, tx, sa, 2'b00};
    assign desc   = base + AW'(offset);
endmodule

// File: rtl/rtd_log_ptr.sv
module rtd_log_ptr #(
    parameter int AW        = 16,
    parameter int LOG_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr
);
    localparam int LW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;

    logic [LW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= (32'(idx_q) == LOG_DEPTH - 1) ? '0 : idx_q + 1'b1;
        end
    end

    assign addr = base + AW'({idx_q, 1'b0});
endmodule

// File: rtl/rt_desc_ctrl.sv
module rt_desc_ctrl
    import rtd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int SA_W      = 5,
    parameter int WC_W      = 6,
    parameter int LOG_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic                         cmd_bcast,
    input  logic                         cmd_tx,
    input  logic                         cmd_mode,
    input  logic [SA_W-1:0]              cmd_sa,
    input  logic [AW-1:0]                desc_base,
    input  logic [AW-1:0]                log_base,
    input  logic [16*(1<<(SA_W-1))-1:0]  ill_regs,
    input  logic                         irq_en,
    input  logic                         msg_done,
    input  logic [WC_W-1:0]              msg_words,
    input  logic [DW-1:0]                msg_info,
    input  logic [DW-1:0]                msg_tag,
    output logic                         dma_req,
    input  logic                         dma_gnt_n,
    output logic [AW-1:0]                mem_addr,
    output logic                         mem_rd,
    output logic                         mem_wr,
    output logic [DW-1:0]                mem_wdata,
    input  logic [DW-1:0]                mem_rdata,
    output logic                         cmd_illegal,
    output logic                         buf_valid,
    output logic [AW-1:0]                buf_addr,
    output logic                         msg_irq
);
    rtd_state_t state_q, state_d;
    logic [2:0]    beat_q, last_q;
    logic [AW-1:0] desc_q, top_q, cur_q, mib_q;
    logic [DW-1:0] ctl_q, info_q, tag_q;
    logic          illegal_q, irq_q;
    logic          legal, log_adv;
    logic [AW-1:0] desc_addr, log_addr;

    rtd_legality #(.SA_W(SA_W)) u_legal (
        .bcast(cmd_bcast), .tx(cmd_tx), .mode(cmd_mode), .sa(cmd_sa),
        .regs(ill_regs), .legal(legal)
    );

    rtd_addr_gen #(.AW(AW), .SA_W(SA_W)) u_addr (
        .base(desc_base), .tx(cmd_tx), .mode(cmd_mode), .sa(cmd_sa),
        .desc(desc_addr)
    );

    assign log_adv = (state_q == ST_WRITE) && (beat_q == last_q) && (last_q == LAST_LONG);

    rtd_log_ptr #(.AW(AW), .LOG_DEPTH(LOG_DEPTH)) u_log (
        .clk(clk), .rst_n(rst_n), .adv(log_adv), .base(log_base), .addr(log_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid && legal) state_d = ST_FREQ;
            ST_FREQ:   if (!dma_gnt_n) state_d = ST_FETCH;
            ST_FETCH:  if (beat_q == 3'd3) state_d = ST_ACTIVE;
            ST_ACTIVE: if (msg_done) state_d = ST_WREQ;
            ST_WREQ:   if (!dma_gnt_n) state_d = ST_WRITE;
            ST_WRITE:  if (beat_q == last_q) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            beat_q    <= '0;
            last_q    <= LAST_SHORT;
            desc_q    <= '0;
            top_q     <= '0;
            cur_q     <= '0;
            mib_q     <= '0;
            ctl_q     <= '0;
            info_q    <= '0;
            tag_q     <= '0;
            illegal_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= (state_q == ST_IDLE) && cmd_valid && !legal;
            irq_q     <= log_adv;
            if (state_d != state_q) beat_q <= '0;
            else if (state_q == ST_FETCH || state_q == ST_WRITE) beat_q <= beat_q + 3'd1;
            if (state_q == ST_IDLE && cmd_valid) desc_q <= desc_addr;
            if (state_q == ST_FETCH) begin
                case (beat_q[1:0])
                    2'd0:    ctl_q <= mem_rdata;
                    2'd1:    top_q <= AW'(mem_rdata);
                    2'd2:    cur_q <= AW'(mem_rdata);
                    default: mib_q <= AW'(mem_rdata);
                endcase
            end
            if (state_q == ST_ACTIVE && msg_done) begin
                info_q <= msg_info;
                tag_q  <= msg_tag;
                cur_q  <= ctl_q[CTL_WRAP_BIT] ? top_q : cur_q + AW'(msg_words);
                last_q <= (ctl_q[CTL_IWA_BIT] && irq_en) ? LAST_LONG : LAST_SHORT;
            end
        end
    end

    // outputs
    always_comb begin
        dma_req   = (state_q == ST_FREQ) || (state_q == ST_FETCH) ||
                    (state_q == ST_WREQ) || (state_q == ST_WRITE);
        mem_rd    = (state_q == ST_FETCH);
        mem_wr    = (state_q == ST_WRITE);
        mem_addr  = '0;
        mem_wdata = '0;
        if (state_q == ST_FETCH) begin
            mem_addr = desc_q + AW'(beat_q);
        end else if (state_q == ST_WRITE) begin
            case (beat_q)
                3'd0:    begin mem_addr = mib_q;        mem_wdata = info_q;      end
                3'd1:    begin mem_addr = mib_q + 1'b1; mem_wdata = tag_q;       end
                3'd2:    begin mem_addr = desc_q + 2'd2; mem_wdata = DW'(cur_q); end
                3'd3:    begin mem_addr = desc_q;       mem_wdata = ctl_q;       end
                3'd4:    begin mem_addr = log_addr;     mem_wdata = info_q;      end
                default: begin mem_addr = log_addr + 1'b1; mem_wdata = DW'(desc_q); end
            endcase
        end
        buf_valid   = (state_q == ST_ACTIVE);
        buf_addr    = cur_q;
        cmd_illegal = illegal_q;
        msg_irq     = irq_q;
    end

    assert_mem_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (dma_req && !dma_gnt_n));
    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_illegal_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |-> (!dma_req && !mem_rd && !mem_wr));
    assert_bctx_mode_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_valid && cmd_bcast && cmd_tx && cmd_mode && cmd_sa[SA_W-1])
        |=> cmd_illegal);
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_irq |=> !msg_irq);
    assert_buf_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> !dma_req);
endmodule

// File: tb/rt_desc_ctrl_test.sv
`timescale 1ns/1ps
module rt_desc_ctrl_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, cmd_valid, cmd_bcast, cmd_tx, cmd_mode, irq_en, msg_done;
    logic [4:0]  cmd_sa;
    logic [15:0] desc_base, log_base, msg_info, msg_tag, mem_addr, mem_wdata, buf_addr;
    logic [15:0] mem_rdata;
    logic [255:0] ill_regs;
    logic [5:0]  msg_words;
    logic        dma_req, dma_gnt_n, mem_rd, mem_wr, cmd_illegal, buf_valid, msg_irq;

    rt_desc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast),
        .cmd_tx(cmd_tx), .cmd_mode(cmd_mode), .cmd_sa(cmd_sa), .desc_base(desc_base),
        .log_base(log_base), .ill_regs(ill_regs), .irq_en(irq_en), .msg_done(msg_done),
        .msg_words(msg_words), .msg_info(msg_info), .msg_tag(msg_tag), .dma_req(dma_req),
        .dma_gnt_n(dma_gnt_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cmd_illegal(cmd_illegal),
        .buf_valid(buf_valid), .buf_addr(buf_addr), .msg_irq(msg_irq)
    );

    typedef struct packed { logic wr; logic [15:0] addr; logic [15:0] data; } item_t;
    item_t exp_q[$];
    logic [15:0] mem    [logic [15:0]];
    logic [15:0] shadow [logic [15:0]];
    int checks = 0, errors = 0, irq_cnt = 0, log_idx = 0, gnt_delay = 0, gnt_cnt = 0, cyc = 0, nmsg = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sh(input logic [15:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    task automatic put(input logic [15:0] a, input logic [15:0] d);
        mem[a] = d;
        shadow[a] = d;
    endtask

    task automatic push(input logic wr, input logic [15:0] a, input logic [15:0] d);
        exp_q.push_back('{wr: wr, addr: a, data: d});
        if (wr) shadow[a] = d;
    endtask

    // memory model: write at the edge, read data presented by mid-cycle
    always @(posedge clk) if (mem_wr) mem[mem_addr] = mem_wdata;
    always @(negedge clk) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;

    // grant model with programmable delay
    always @(posedge clk) begin
        if (!rst_n) begin
            gnt_cnt <= 0; dma_gnt_n <= 1'b1;
        end else if (dma_req) begin
            if (gnt_cnt >= gnt_delay) dma_gnt_n <= 1'b0;
            gnt_cnt <= gnt_cnt + 1;
        end else begin
            gnt_cnt <= 0; dma_gnt_n <= 1'b1;
        end
    end

    // monitor: pop and compare every bus access
    always @(negedge clk) begin
        if (rst_n) begin
            if (msg_irq) irq_cnt++;
            if (mem_rd || mem_wr) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R7 unexpected access", {15'd0, mem_wr, mem_addr}, 32'h0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.wr == mem_wr, it.wr ? "R7 access kind" : "R4 access kind", 32'(mem_wr), 32'(it.wr));
                    chk(it.addr == mem_addr, it.wr ? "R7 write address" : "R4 read address", 32'(mem_addr), 32'(it.addr));
                    if (it.wr) chk(it.data == mem_wdata, "R7/R8 write data", 32'(mem_wdata), 32'(it.data));
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] dsc(input logic t, input logic m, input logic [4:0] sa);
        return desc_base + {7'd0, m, t, sa, 2'b00};
    endfunction

    task automatic drive_cmd(input logic b, input logic t, input logic m, input logic [4:0] sa);
        cmd_bcast = b; cmd_tx = t; cmd_mode = m; cmd_sa = sa; cmd_valid = 1'b1;
    endtask

    task automatic send_bad(input logic b, input logic t, input logic m, input logic [4:0] sa, input string req);
        drive_cmd(b, t, m, sa);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_illegal == 1'b1, req, 32'(cmd_illegal), 32'd1);
        @(negedge clk);
        chk(cmd_illegal == 1'b0, "R3 flag one cycle", 32'(cmd_illegal), 32'd0);
        for (int i = 0; i < 6; i++) begin
            chk(!dma_req && !mem_rd && !mem_wr, "R3 no bus activity", {29'd0, dma_req, mem_rd, mem_wr}, 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic send(input logic b, input logic t, input logic m, input logic [4:0] sa,
                        input logic [5:0] words, input logic ien, input bit poke);
        logic [15:0] d, ctl, top, cur, mib, ncur, info, tag;
        int cycles, irq0;
        nmsg++;
        info = 16'hA000 + 16'(nmsg);
        tag  = 16'h5000 + 16'(nmsg);
        d = dsc(t, m, sa);
        ctl = sh(d); top = sh(d + 16'd1); cur = sh(d + 16'd2); mib = sh(d + 16'd3);
        for (int i = 0; i < 4; i++) push(1'b0, d + 16'(i), 16'h0);
        irq_en = ien;
        drive_cmd(b, t, m, sa);
        cycles = 0;
        do begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cycles++;
        end while (!mem_rd && cycles < 100);
        chk(cycles == gnt_delay + 3, "R5 first read after grant", 32'(cycles), 32'(gnt_delay + 3));
        cycles = 0;
        while (!buf_valid && cycles < 100) begin @(negedge clk); cycles++; end
        chk(buf_valid == 1'b1, "R6 buffer valid", 32'(buf_valid), 32'd1);
        chk(buf_addr == cur, "R6 buffer address", 32'(buf_addr), 32'(cur));
        if (poke) begin
            drive_cmd(1'b1, 1'b1, 1'b1, 5'd20);
            @(negedge clk);
            cmd_valid = 1'b0;
            @(negedge clk);
            chk(cmd_illegal == 1'b0, "R10 busy command ignored", 32'(cmd_illegal), 32'd0);
            chk(buf_valid && buf_addr == cur, "R10 message unchanged", 32'(buf_addr), 32'(cur));
        end
        ncur = ctl[6] ? top : cur + 16'(words);
        push(1'b1, mib, info);
        push(1'b1, mib + 16'd1, tag);
        push(1'b1, d + 16'd2, ncur);
        push(1'b1, d, ctl);
        if (ctl[8] && ien) begin
            push(1'b1, log_base + 16'(2 * log_idx), info);
            push(1'b1, log_base + 16'(2 * log_idx) + 16'd1, d);
            log_idx = (log_idx + 1) % 4;
        end
        irq0 = irq_cnt;
        msg_words = words; msg_info = info; msg_tag = tag; msg_done = 1'b1;
        @(negedge clk);
        msg_done = 1'b0;
        cycles = 0;
        while (exp_q.size() != 0 && cycles < 100) begin @(negedge clk); cycles++; end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 write-back complete", 32'(exp_q.size()), 32'd0);
        chk(irq_cnt - irq0 == ((ctl[8] && ien) ? 1 : 0), "R9 interrupt pulse count",
            32'(irq_cnt - irq0), 32'((ctl[8] && ien) ? 1 : 0));
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_bcast = 1'b0; cmd_tx = 1'b0; cmd_mode = 1'b0;
        cmd_sa = '0; irq_en = 1'b0; msg_done = 1'b0; msg_words = '0; msg_info = '0; msg_tag = '0;
        desc_base = 16'h1100; log_base = 16'h2200; ill_regs = '0;
        ill_regs[0*16 + 5] = 1'b1;   // receive SA5
        ill_regs[5*16 + 2] = 1'b1;   // broadcast receive SA18
        put(16'h1104, 16'h0140); put(16'h1105, 16'h801A); put(16'h1106, 16'h801A); put(16'h1107, 16'h0000);
        put(16'h1184, 16'h0140); put(16'h1185, 16'h8000); put(16'h1186, 16'h8000); put(16'h1187, 16'h0004);
        put(16'h1188, 16'h0000); put(16'h1189, 16'hF777); put(16'h118A, 16'hF777); put(16'h118B, 16'h0008);
        put(16'h1244, 16'h0040); put(16'h1245, 16'h001A); put(16'h1246, 16'h0030); put(16'h1247, 16'h0010);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dma_req, mem_rd, mem_wr, cmd_illegal, buf_valid, msg_irq} == 6'b0, "R3 reset state",
            32'({dma_req, mem_rd, mem_wr, cmd_illegal, buf_valid, msg_irq}), 32'd0);

        send(1'b0, 1'b0, 1'b0, 5'd1, 6'd4, 1'b1, 1'b0);  // R9 log entry 0, R8 wrap
        send(1'b0, 1'b1, 1'b0, 5'd1, 6'd26, 1'b1, 1'b0); // R4 transmit table
        gnt_delay = 5;
        send(1'b0, 1'b1, 1'b0, 5'd2, 6'd1, 1'b1, 1'b0);  // R8 advance, R5 delayed grant
        send(1'b0, 1'b1, 1'b0, 5'd2, 6'd2, 1'b1, 1'b0);  // R6 advanced pointer seen
        gnt_delay = 0;
        send(1'b0, 1'b0, 1'b1, 5'd17, 6'd3, 1'b1, 1'b0); // R4 mode table, R8 wrap without log
        send(1'b0, 1'b0, 1'b0, 5'd1, 6'd4, 1'b0, 1'b0);  // R9 irq_en low: 4 words
        send_bad(1'b0, 1'b0, 1'b0, 5'd5, "R1 lower-half bitmap");
        send_bad(1'b1, 1'b0, 1'b0, 5'd18, "R1 upper-half bitmap");
        send(1'b0, 1'b0, 1'b0, 5'd18, 6'd2, 1'b1, 1'b0); // R1 other category legal
        send_bad(1'b1, 1'b1, 1'b1, 5'd20, "R2 forced illegal mode 20");
        send_bad(1'b1, 1'b1, 1'b1, 5'd31, "R2 forced illegal mode 31");
        send(1'b1, 1'b1, 1'b1, 5'd15, 6'd0, 1'b1, 1'b0); // R2 mode 15 stays legal
        send(1'b0, 1'b0, 1'b0, 5'd1, 6'd4, 1'b1, 1'b1);  // R10 busy poke, log entry 2
        send(1'b0, 1'b0, 1'b0, 5'd1, 6'd4, 1'b1, 1'b0);  // log entry 3
        send(1'b0, 1'b0, 1'b0, 5'd1, 6'd4, 1'b1, 1'b0);  // R9 log wraps to entry 0

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule